// File: doc/BRIEF.md
# Target Write Termination Controller

This block makes the termination decision for a target write burst aimed at a prefetchable region whose data lands in a command/write data buffer. An address phase opens a transaction and latches its start address. For each data phase offered, the block looks at the buffer-full flag, at whether the transaction has already moved any data, and at the burst addressing mode. It then answers with one of three outcomes: take the phase, retry the whole write, or disconnect.

A disconnect, a limit hit, or a normal end of the bus transaction closes the data moved so far into one command. The block reports that command through a one-cycle strobe that carries the data-phase count and the start address. A retry leaves nothing behind. A write that comes back after a retry or a disconnect is a fresh transaction with its own address phase and its own command. Bus pin timing, the buffer storage and the local write engine sit outside this block.

Top module: `twt_top`

## Requirements
- R1: When a data phase is offered with the buffer full and no phase of the transaction has been taken yet, `stop_retry` pulses one cycle later. In that cycle `phase_accept`, `stop_disconnect` and `commit_strobe` stay low.
- R2: After a retry, further data phases and the end of that transaction produce no output. The next address phase starts a new transaction with a count of zero and the new start address.
- R3: When a data phase is offered with the buffer full after one or more phases have been taken, `stop_disconnect` pulses one cycle later and `phase_accept` stays low.
- R4: Every disconnect pulses `commit_strobe` in the same cycle. `commit_len` then equals the number of phases taken and `commit_addr` equals the latched start address.
- R5: After a disconnect, the rest of that transaction produces no output. A resumed write opened by a new address phase yields its own separate commit.
- R6: In wrap addressing mode (`wrap_mode`=1), the first phase offered with space is taken and disconnected in the same cycle, with `commit_len`=1.
- R7: The only terminations are retry and disconnect. `stop_retry` never occurs together with `phase_accept` or `stop_disconnect`.
- R8: Taking the MAX_PHASES-th phase of a transaction signals accept and disconnect together, with `commit_len`=MAX_PHASES.
- R9: `txn_end` after one or more taken phases (with no earlier termination) pulses `commit_strobe` one cycle later, with the count and without a disconnect. `txn_end` with zero phases taken commits nothing.
- R10: A phase offered with the buffer full is never accepted. Every result is registered and appears exactly one cycle after the input cycle. Inputs outside an open transaction are ignored.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Address phase strobe; opens a new transaction |
| txn_addr | input | ADDR_W | Start address, latched with `txn_start` |
| wrap_mode | input | 1 | 1 = cacheline wrap burst addressing |
| phase_req | input | 1 | A data phase is offered this cycle |
| buf_full | input | 1 | Buffer has no room for another phase |
| txn_end | input | 1 | Bus returned to idle; transaction over |
| phase_accept | output | 1 | Phase taken into the buffer |
| stop_retry | output | 1 | Retry termination, nothing kept |
| stop_disconnect | output | 1 | Disconnect termination |
| commit_strobe | output | 1 | One-cycle command commit |
| commit_len | output | LEN_W | Data phases in the committed command |
| commit_addr | output | ADDR_W | Start address of the committed command |

## Verification
All outputs are registered. Each outcome belongs to the input cycle one clock earlier: the phase decision, the termination, and the commit of a disconnect or an end. The bench drives inputs on the falling edge. For every driven cycle it queues one expected output set, including the idle all-zero set. A monitor pops and compares that set a quarter period after the next rising edge, so no result is read in the cycle of its stimulus.

// File: rtl/twt_pkg.sv
package twt_pkg;

  typedef struct packed {
    logic take;   // phase goes into the buffer
    logic retry;  // terminate, forget everything
    logic stop;   // terminate after keeping what was taken
  } twt_verdict_t;

  // Decide one data phase from space, progress, burst mode and length limit.
  function automatic twt_verdict_t twt_judge(input logic full, input logic started,
                                             input logic wrap, input logic at_limit);
    twt_verdict_t v;
    v = '0;
    if (full) begin
      if (started) v.stop  = 1'b1;
      else         v.retry = 1'b1;
    end else begin
      v.take = 1'b1;
      if (wrap || at_limit) v.stop = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/twt_judge_unit.sv
module twt_judge_unit
  import twt_pkg::*;
(
  input  logic phase_valid,
  input  logic buf_full,
  input  logic started,
  input  logic wrap_mode,
  input  logic at_limit,
  output logic take,
  output logic retry,
  output logic stop
);
  twt_verdict_t verdict;

  always_comb begin
    verdict = '0;
    if (phase_valid) verdict = twt_judge(buf_full, started, wrap_mode, at_limit);
  end

  assign take  = verdict.take;
  assign retry = verdict.retry;
  assign stop  = verdict.stop;
endmodule

// File: rtl/twt_txn_track.sv
module twt_txn_track #(
  parameter int ADDR_W     = 32,
  parameter int MAX_PHASES = 16,
  localparam int LEN_W     = $clog2(MAX_PHASES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_end,
  input  logic              take,
  input  logic              retry,
  input  logic              stop,
  output logic              open,
  output logic              started,
  output logic              at_limit,
  output logic              commit_fire,
  output logic [LEN_W-1:0]  commit_cnt,
  output logic [ADDR_W-1:0] base_addr
);
  localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(MAX_PHASES - 1);

  logic             active_q, done_q;
  logic [LEN_W-1:0] cnt_q;

  function automatic logic [LEN_W-1:0] next_len(input logic [LEN_W-1:0] c, input logic t);
    return c + LEN_W'(t);
  endfunction

  assign open        = active_q && !done_q;
  assign started     = (cnt_q != '0);
  assign at_limit    = (cnt_q == LAST_IDX);
  assign commit_cnt  = next_len(cnt_q, take);
  assign commit_fire = stop || (txn_end && open && !txn_start && (commit_cnt != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      base_addr <= '0;
    end else if (txn_start) begin
      active_q  <= 1'b1;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      base_addr <= txn_addr;
    end else if (txn_end) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (retry || stop) begin
      done_q    <= 1'b1;
      cnt_q     <= '0;
    end else begin
      cnt_q     <= commit_cnt;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LEN_W'(MAX_PHASES)) else $error("count past limit"); // R8

  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> !take && !retry && !stop) else $error("verdict outside open txn"); // R2
endmodule

// File: rtl/twt_top.sv
module twt_top #(
  parameter int ADDR_W     = 32,
  parameter int MAX_PHASES = 16,
  localparam int LEN_W     = $clog2(MAX_PHASES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              wrap_mode,
  input  logic              phase_req,
  input  logic              buf_full,
  input  logic              txn_end,
  output logic              phase_accept,
  output logic              stop_retry,
  output logic              stop_disconnect,
  output logic              commit_strobe,
  output logic [LEN_W-1:0]  commit_len,
  output logic [ADDR_W-1:0] commit_addr
);
  logic              open, started, at_limit, phase_valid;
  logic              take, retry, stop, commit_fire;
  logic [LEN_W-1:0]  commit_cnt;
  logic [ADDR_W-1:0] base_addr;

  assign phase_valid = phase_req && open && !txn_start;

  twt_judge_unit u_judge (
    .phase_valid (phase_valid),
    .buf_full    (buf_full),
    .started     (started),
    .wrap_mode   (wrap_mode),
    .at_limit    (at_limit),
    .take        (take),
    .retry       (retry),
    .stop        (stop)
  );

  twt_txn_track #(.ADDR_W(ADDR_W), .MAX_PHASES(MAX_PHASES)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .txn_addr    (txn_addr),
    .txn_end     (txn_end),
    .take        (take),
    .retry       (retry),
    .stop        (stop),
    .open        (open),
    .started     (started),
    .at_limit    (at_limit),
    .commit_fire (commit_fire),
    .commit_cnt  (commit_cnt),
    .base_addr   (base_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_accept    <= 1'b0;
      stop_retry      <= 1'b0;
      stop_disconnect <= 1'b0;
      commit_strobe   <= 1'b0;
      commit_len      <= '0;
      commit_addr     <= '0;
    end else begin
      phase_accept    <= take;
      stop_retry      <= retry;
      stop_disconnect <= stop;
      commit_strobe   <= commit_fire;
      commit_len      <= commit_fire ? commit_cnt : '0;
      commit_addr     <= commit_fire ? base_addr  : '0;
    end
  end

  AST_RETRY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_retry |-> !phase_accept && !stop_disconnect && !commit_strobe) else $error("retry mixed"); // R7

  AST_FULL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req && buf_full |=> !phase_accept) else $error("phase taken while full"); // R10

  AST_DISC_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_disconnect |-> commit_strobe && (commit_len != '0)) else $error("disconnect w/o commit"); // R4

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid && wrap_mode && !buf_full |=> stop_disconnect && phase_accept && (commit_len == LEN_W'(1)))
    else $error("wrap burst not single"); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_req && !txn_end |=> !phase_accept && !stop_retry && !stop_disconnect && !commit_strobe)
    else $error("output without stimulus"); // R10
endmodule

// File: tb/tb_twt_top.sv
module tb_twt_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int MAXP = 16;
  localparam int LW   = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, wrap_mode = 0, phase_req = 0, buf_full = 0, txn_end = 0;
  logic [AW-1:0] txn_addr = '0;
  logic phase_accept, stop_retry, stop_disconnect, commit_strobe;
  logic [LW-1:0] commit_len;
  logic [AW-1:0] commit_addr;

  int checks = 0, errors = 0;

  typedef struct {
    logic acc, rty, dsc, cmt;
    logic [LW-1:0] len;
    logic [AW-1:0] addr;
    string tag;
  } exp_t;
  exp_t sb[$];

  bit m_act = 0, m_done = 0;
  int m_cnt = 0;
  logic [AW-1:0] m_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twt_top #(.ADDR_W(AW), .MAX_PHASES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
    .wrap_mode(wrap_mode), .phase_req(phase_req), .buf_full(buf_full), .txn_end(txn_end),
    .phase_accept(phase_accept), .stop_retry(stop_retry), .stop_disconnect(stop_disconnect),
    .commit_strobe(commit_strobe), .commit_len(commit_len), .commit_addr(commit_addr)
  );

  task automatic set_commit(inout exp_t e);
    e.cmt = 1; e.len = LW'(m_cnt); e.addr = m_addr;
  endtask

  // Driver: drive one cycle and queue what the requirements say must follow.
  task automatic step(input logic s, input logic [AW-1:0] a, input logic w,
                      input logic rq, input logic f, input logic en, input string tag);
    exp_t e;
    @(negedge clk);
    txn_start = s; txn_addr = a; wrap_mode = w; phase_req = rq; buf_full = f; txn_end = en;
    e.acc = 0; e.rty = 0; e.dsc = 0; e.cmt = 0; e.len = '0; e.addr = '0; e.tag = tag;
    if (s) begin
      m_act = 1; m_done = 0; m_cnt = 0; m_addr = a;
    end else begin
      if (rq && m_act && !m_done) begin
        if (f) begin
          if (m_cnt == 0) begin e.rty = 1; m_done = 1; end
          else begin e.dsc = 1; set_commit(e); m_done = 1; end
        end else begin
          e.acc = 1; m_cnt++;
          if (w || m_cnt == MAXP) begin e.dsc = 1; set_commit(e); m_done = 1; end
        end
      end
      if (en) begin
        if (m_act && !m_done && m_cnt != 0) set_commit(e);
        m_act = 0; m_done = 0; m_cnt = 0;
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, "R10 idle");
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (phase_accept !== e.acc || stop_retry !== e.rty || stop_disconnect !== e.dsc ||
            commit_strobe !== e.cmt || commit_len !== e.len || commit_addr !== e.addr) begin
          errors++;
          $display("FAIL %s: got acc=%b rty=%b dsc=%b cmt=%b len=%0d addr=%h exp acc=%b rty=%b dsc=%b cmt=%b len=%0d addr=%h",
                   e.tag, phase_accept, stop_retry, stop_disconnect, commit_strobe, commit_len, commit_addr,
                   e.acc, e.rty, e.dsc, e.cmt, e.len, e.addr);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if ({phase_accept, stop_retry, stop_disconnect, commit_strobe} !== 4'b0 || commit_len !== '0 || commit_addr !== '0) begin
      errors++;
      $display("FAIL R11 reset: got %b%b%b%b exp 0000", phase_accept, stop_retry, stop_disconnect, commit_strobe);
    end
    @(negedge clk); rst_n = 1'b1;

    // stray phase with no transaction open
    step(0, '0, 0, 1, 0, 0, "R10 no txn");
    // normal transaction: three phases then end
    step(1, 32'h1000_0040, 0, 0, 0, 0, "R9 addr");
    step(0, '0, 0, 1, 0, 0, "R9 take1");
    step(0, '0, 0, 1, 0, 0, "R9 take2");
    step(0, '0, 0, 0, 0, 0, "R10 wait");
    step(0, '0, 0, 1, 0, 0, "R9 take3");
    step(0, '0, 0, 0, 0, 1, "R9 end commit");
    idle(2);
    // retry on first phase
    step(1, 32'h2000_0000, 0, 0, 0, 0, "R1 addr");
    step(0, '0, 0, 1, 1, 0, "R1 R7 retry");
    step(0, '0, 0, 1, 0, 0, "R2 ignored after retry");
    step(0, '0, 0, 0, 0, 1, "R2 end no commit");
    step(1, 32'h2000_0100, 0, 0, 0, 0, "R2 reissue addr");
    step(0, '0, 0, 1, 0, 0, "R2 fresh take");
    step(0, '0, 0, 1, 0, 1, "R2 take with end");
    idle(1);
    // disconnect after progress
    step(1, 32'h3000_0080, 0, 0, 0, 0, "R3 addr");
    step(0, '0, 0, 1, 0, 0, "R3 take1");
    step(0, '0, 0, 1, 0, 0, "R3 take2");
    step(0, '0, 0, 1, 1, 0, "R3 R4 disconnect");
    step(0, '0, 0, 1, 0, 0, "R5 ignored after disc");
    step(0, '0, 0, 1, 1, 0, "R5 ignored full");
    step(0, '0, 0, 0, 0, 1, "R5 end no commit");
    step(1, 32'h3000_0088, 0, 0, 0, 0, "R5 resume addr");
    step(0, '0, 0, 1, 0, 0, "R5 resume take");
    step(0, '0, 0, 0, 0, 1, "R5 resume commit");
    idle(1);
    // wrap mode
    step(1, 32'h4000_0010, 1, 0, 0, 0, "R6 addr");
    step(0, '0, 1, 1, 0, 0, "R6 single phase");
    step(0, '0, 1, 1, 0, 0, "R6 second ignored");
    step(0, '0, 1, 0, 0, 1, "R6 end");
    // wrap with full buffer still retries
    step(1, 32'h4000_0020, 1, 0, 0, 0, "R6 addr2");
    step(0, '0, 1, 1, 1, 0, "R1 R7 wrap retry");
    step(0, '0, 0, 0, 0, 1, "R2 end");
    // limit
    step(1, 32'h5000_0000, 0, 0, 0, 0, "R8 addr");
    for (int i = 0; i < MAXP; i++) step(0, '0, 0, 1, 0, 0, "R8 take");
    step(0, '0, 0, 1, 0, 0, "R8 ignored past limit");
    step(0, '0, 0, 0, 0, 1, "R8 end");
    // empty transaction
    step(1, 32'h6000_0000, 0, 0, 0, 0, "R9 empty addr");
    step(0, '0, 0, 0, 0, 1, "R9 empty end");
    idle(3);
    wait (sb.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule